// File: doc/BRIEF.md
# Streaming Frame Classifier Engine

This block classifies an incoming frame while it streams past as 16-bit words. A small program, loaded through a configuration write port, holds one instruction per word position. Each accepted word executes exactly the instruction whose address equals that word's index. The instruction tests one already-received word against an immediate value, using a per-nibble enable mask. It then folds the outcome into one of sixteen single-bit flags. The engine never stalls: the program counter moves forward once per arriving word, whatever the program does.

The engine stops at one of two points. The first is the word whose index equals the programmed last address. The second is a word marked end-of-frame, if that comes sooner. At that point the engine raises a one-cycle done strobe, and the flag vector then holds the classification result. Further words are dropped until the next start-of-frame. An instruction that reads a word which has not yet arrived is a programming error. It evaluates as a mismatch and sets a sticky error output.

Top module: `frame_classifier`

## Requirements
- R1: A configuration write stores cfgData at program address cfgAddr. The instruction layout is op in bits 31:30 (0 = no-op, 1 = move, 2 = and, 3 = or), destination flag in bits 29:26, word offset in bits 25:20, nibble enables in bits 19:16 (bit n enables word bits 4n+3..4n), and the compare value in bits 15:0.
- R2: A compare is true when the addressed word equals the value on every enabled nibble. With no nibble enabled, a compare is always true.
- R3: The move operation writes the compare result into the destination flag.
- R4: The and operation writes the old flag ANDed with the result. The or operation writes the old flag ORed with the result. A no-op leaves all flags unchanged.
- R5: Exactly one instruction executes per accepted word, at the address equal to the word's index from zero. Idle cycles between words change neither the flags nor the program position.
- R6: A word marked start-of-frame resets the index to zero and clears all flags. Instruction 0 sees every old flag as zero.
- R7: The cycle after the word at index progEnd is accepted, done is high for one cycle and flags hold the final result.
- R8: A word marked end-of-frame at an index below progEnd ends classification in the same way, with done the following cycle.
- R9: After done, words without start-of-frame are ignored. Flags stay unchanged and no further done occurs.
- R10: An executed instruction (not a no-op) whose offset exceeds its own address gives a false compare and sets progErr. progErr then stays set until reset.
- R11: After reset, flags, done and progErr are all zero.
- R12: A start-of-frame word arriving in the middle of a frame abandons that frame and restarts classification at index zero.
- R13: An offset equal to the instruction's own address compares against the word arriving in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Program memory write enable |
| cfgAddr | input | 6 | Program memory write address |
| cfgData | input | 32 | Instruction to write |
| progEnd | input | 6 | Address of the last instruction to execute |
| wordValid | input | 1 | A frame word is present on wordData |
| sof | input | 1 | Marks the first word of a frame |
| eof | input | 1 | Marks the last word of a frame |
| wordData | input | 16 | Frame word; bytes 2N and 2N+1 of the frame, big-endian |
| flags | output | 16 | Classification flag vector |
| done | output | 1 | One-cycle strobe when classification ends |
| progErr | output | 1 | Sticky offset-beyond-address error |

## Verification
Every result of this engine is registered once. The flag update and the error bit for a word, and the done strobe for the last executed word, become visible one rising edge after the word is presented. The bench drives words on falling edges and lets a monitor sample done and flags on every falling edge, so each word's effect is read half a cycle after the edge that accepted it. Expected flags, the word index at which done must appear and the error state come from a bench model of the program. The model stops at the earlier of progEnd and end-of-frame. The bench compares the monitor's record against the model after each frame, including frames with idle gaps between words.

// File: rtl/fc_pkg.sv
package fc_pkg;
  localparam int WORD_W     = 16;
  localparam int NIB_N      = WORD_W / 4;
  localparam int PROG_DEPTH = 64;
  localparam int ADDR_W     = $clog2(PROG_DEPTH);
  localparam int FLAG_N     = 16;
  localparam int FLAG_W     = $clog2(FLAG_N);

  typedef enum logic [1:0] {
    OP_NOP = 2'd0,
    OP_MOV = 2'd1,
    OP_AND = 2'd2,
    OP_OR  = 2'd3
  } op_e;

  // Field order fixes the configuration word layout (R1).
  typedef struct packed {
    op_e               op;
    logic [FLAG_W-1:0] dst;
    logic [ADDR_W-1:0] offset;
    logic [NIB_N-1:0]  nibEn;
    logic [WORD_W-1:0] value;
  } instr_t;

  localparam int INSTR_W = $bits(instr_t);

  // Strobes from control to datapath.
  typedef struct packed {
    logic              exec;
    logic              first;
    logic [ADDR_W-1:0] idx;
  } ctl_t;
endpackage

// File: rtl/fc_control.sv
module fc_control
  import fc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wordValid,
  input  logic              sof,
  input  logic              eof,
  input  logic [ADDR_W-1:0] progEnd,
  output ctl_t              ctl,
  output logic              done
);
  logic [ADDR_W-1:0] pcQ;
  logic              activeQ;
  logic              doneQ;
  logic              accept;
  logic              finish;
  logic [ADDR_W-1:0] idx;

  always_comb begin
    accept    = wordValid && (sof || activeQ);
    idx       = sof ? '0 : pcQ;
    finish    = accept && (eof || (idx == progEnd));
    ctl.exec  = accept;
    ctl.first = wordValid && sof;
    ctl.idx   = idx;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcQ     <= '0;
      activeQ <= 1'b0;
      doneQ   <= 1'b0;
    end else begin
      doneQ <= finish;
      if (accept) begin
        activeQ <= !finish;
        pcQ     <= finish ? '0 : ADDR_W'(idx + 1'b1);
      end
    end
  end

  assign done = doneQ;

  // R5: no word, no movement and no done
  p_pc_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !wordValid |=> ($stable(pcQ) && !doneQ));

  // R7: done only ever follows an accepted word
  p_done_src_r7: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |-> $past(wordValid));

  // R9: stray words after completion are dropped
  p_drop_r9: assert property (@(posedge clk) disable iff (!rstN)
    (wordValid && !sof && !activeQ) |=> (!doneQ && $stable(pcQ)));

  // R12: start of frame always restarts at index zero
  p_restart_r12: assert property (@(posedge clk) disable iff (!rstN)
    (wordValid && sof && !eof && (progEnd != '0)) |=> (pcQ == ADDR_W'(1) && activeQ));
endmodule

// File: rtl/fc_datapath.sv
module fc_datapath
  import fc_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWe,
  input  logic [ADDR_W-1:0]  cfgAddr,
  input  logic [INSTR_W-1:0] cfgData,
  input  ctl_t               ctl,
  input  logic [WORD_W-1:0]  wordData,
  output logic [FLAG_N-1:0]  flags,
  output logic               progErr
);
  instr_t            progMem [PROG_DEPTH];
  logic [WORD_W-1:0] wordBuf [PROG_DEPTH];
  instr_t            curIns;
  logic [WORD_W-1:0] selWord;
  logic [NIB_N-1:0]  nibOk;
  logic              early;
  logic              hit;
  logic              fault;
  logic [FLAG_N-1:0] baseFlags;
  logic [FLAG_N-1:0] nxtFlags;
  logic [FLAG_N-1:0] flagQ;
  logic              errQ;

  always_ff @(posedge clk) begin
    if (cfgWe) progMem[cfgAddr] <= instr_t'(cfgData);
    if (ctl.exec) wordBuf[ctl.idx] <= wordData;
  end

  assign curIns  = progMem[ctl.idx];
  assign early   = curIns.offset > ctl.idx;
  // Offset equal to the current index reads the arriving word (R13)
  assign selWord = (curIns.offset == ctl.idx) ? wordData : wordBuf[curIns.offset];

  for (genvar n = 0; n < NIB_N; n++) begin : g_nib
    assign nibOk[n] = !curIns.nibEn[n] ||
                      (selWord[4*n +: 4] == curIns.value[4*n +: 4]);
  end

  assign hit   = (&nibOk) && !early;
  assign fault = ctl.exec && (curIns.op != OP_NOP) && early;

  always_comb begin
    baseFlags = ctl.first ? '0 : flagQ;
    nxtFlags  = baseFlags;
    unique case (curIns.op)
      OP_MOV:  nxtFlags[curIns.dst] = hit;
      OP_AND:  nxtFlags[curIns.dst] = baseFlags[curIns.dst] & hit;
      OP_OR:   nxtFlags[curIns.dst] = baseFlags[curIns.dst] | hit;
      default: nxtFlags = baseFlags;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagQ <= '0;
      errQ  <= 1'b0;
    end else begin
      if (ctl.exec) flagQ <= nxtFlags;
      if (fault)    errQ  <= 1'b1;
    end
  end

  assign flags   = flagQ;
  assign progErr = errQ;

  // R5: flags only move on an executed word
  p_idle_flags_r5: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.exec |=> $stable(flagQ));

  // R4: a no-op in mid-frame keeps every flag
  p_nop_keep_r4: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.exec && !ctl.first && curIns.op == OP_NOP) |=> $stable(flagQ));

  // R6: frame start with a no-op leaves all flags clear
  p_first_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.exec && ctl.first && curIns.op == OP_NOP) |=> (flagQ == '0));

  // R10: error bit is sticky
  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    errQ |=> errQ);
endmodule

// File: rtl/frame_classifier.sv
module frame_classifier
  import fc_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWe,
  input  logic [ADDR_W-1:0]  cfgAddr,
  input  logic [INSTR_W-1:0] cfgData,
  input  logic [ADDR_W-1:0]  progEnd,
  input  logic               wordValid,
  input  logic               sof,
  input  logic               eof,
  input  logic [WORD_W-1:0]  wordData,
  output logic [FLAG_N-1:0]  flags,
  output logic               done,
  output logic               progErr
);
  ctl_t ctl;

  fc_control u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .wordValid (wordValid),
    .sof       (sof),
    .eof       (eof),
    .progEnd   (progEnd),
    .ctl       (ctl),
    .done      (done)
  );

  fc_datapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .cfgWe    (cfgWe),
    .cfgAddr  (cfgAddr),
    .cfgData  (cfgData),
    .ctl      (ctl),
    .wordData (wordData),
    .flags    (flags),
    .progErr  (progErr)
  );
endmodule

// File: tb/frame_classifier_bench.sv
module frame_classifier_bench;
  logic        clk = 1'b0;
  logic        rstN;
  logic        cfgWe;
  logic [5:0]  cfgAddr;
  logic [31:0] cfgData;
  logic [5:0]  progEnd;
  logic        wordValid, sof, eof;
  logic [15:0] wordData;
  logic [15:0] flags;
  logic        done, progErr;

  always #10 clk = ~clk;

  frame_classifier u_frame_classifier (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .progEnd(progEnd), .wordValid(wordValid), .sof(sof), .eof(eof),
    .wordData(wordData), .flags(flags), .done(done), .progErr(progErr)
  );

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  logic [31:0] progM [64];
  logic [15:0] frameW [64];
  int wordsSent, doneCnt, doneAt;
  logic [15:0] flagsAtDone;
  bit errExp = 0;

  always @(negedge clk) begin
    if (done) begin
      doneCnt++;
      doneAt = wordsSent - 1;
      flagsAtDone = flags;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mkIns(int op, int dst, int off, int nib, int val);
    return {op[1:0], dst[3:0], off[5:0], nib[3:0], val[15:0]};
  endfunction

  task automatic clearProg();
    for (int i = 0; i < 64; i++) progM[i] = 32'd0;
  endtask

  task automatic loadProg();
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      cfgWe = 1'b1; cfgAddr = 6'(i); cfgData = progM[i];
    end
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic modelRun(input int len, input int endA, output logic [15:0] f,
                          output int last, output bit flt);
    f = '0; flt = 0;
    last = (len - 1 < endA) ? len - 1 : endA;
    for (int k = 0; k <= last; k++) begin
      logic [31:0] ins;
      logic [15:0] w;
      logic m;
      int dst, off;
      ins = progM[k];
      dst = int'(ins[29:26]);
      off = int'(ins[25:20]);
      if (ins[31:30] == 2'd0) continue;
      if (off > k) begin
        flt = 1; m = 1'b0;
      end else begin
        w = frameW[off]; m = 1'b1;
        for (int n = 0; n < 4; n++)
          if (ins[16+n] && (w[4*n +: 4] != ins[4*n +: 4])) m = 1'b0;
      end
      case (ins[31:30])
        2'd1: f[dst] = m;
        2'd2: f[dst] = f[dst] & m;
        default: f[dst] = f[dst] | m;
      endcase
    end
  endtask

  task automatic idle();
    @(negedge clk);
    wordValid = 1'b0; sof = 1'b0; eof = 1'b0;
  endtask

  task automatic sendFrame(input int len, input int maxGap, input bit withEof);
    doneCnt = 0; wordsSent = 0;
    for (int k = 0; k < len; k++) begin
      if (maxGap > 0) repeat ($urandom_range(maxGap, 0)) idle();
      @(negedge clk);
      wordValid = 1'b1; sof = (k == 0); eof = withEof && (k == len - 1);
      wordData = frameW[k];
      @(posedge clk);
      wordsSent++;
    end
    idle();
    idle();
  endtask

  task automatic runFrame(input string tag, input int len, input int endA, input int maxGap);
    logic [15:0] f;
    int last;
    bit flt;
    progEnd = 6'(endA);
    sendFrame(len, maxGap, 1'b1);
    modelRun(len, endA, f, last, flt);
    errExp = errExp | flt;
    check({tag, " flags"}, 32'(flags), 32'(f));
    check("R7 flags at done", 32'(flagsAtDone), 32'(f));
    check("R7 done count", doneCnt, 1);
    check((last < endA) ? "R8 done index" : "R7 done index", doneAt, last);
    check("R10 error bit", 32'(progErr), 32'(errExp));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL R5 watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] held;
    void'($urandom(32'd4711));
    rstN = 1'b0; cfgWe = 1'b0; cfgAddr = '0; cfgData = '0; progEnd = '0;
    wordValid = 1'b0; sof = 1'b0; eof = 1'b0; wordData = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R11 flags", 32'(flags), 0);
    check("R11 done", 32'(done), 0);
    check("R11 error", 32'(progErr), 0);

    // R1 R3 R4: move then and on one flag
    clearProg();
    progM[0] = mkIns(1, 3, 0, 15, 16'hCAFE);
    progM[1] = mkIns(2, 3, 1, 15, 16'hBABE);
    loadProg();
    frameW[0] = 16'hCAFE; frameW[1] = 16'hBABE;
    runFrame("R1", 2, 1, 0);
    check("R3 flag3 set", 32'(flags), 32'h0008);
    frameW[1] = 16'hBABF;
    runFrame("R4", 2, 1, 0);
    check("R4 and clears", 32'(flags), 32'h0000);

    // R2: nibble masks
    clearProg();
    progM[0] = mkIns(1, 0, 0, 4'b1001, 16'hF00F);
    progM[1] = mkIns(1, 1, 1, 4'b0000, 16'h1234);
    progM[2] = mkIns(1, 2, 2, 4'b0110, 16'h0AB0);
    progM[3] = mkIns(1, 5, 0, 4'b0001, 16'h000E);
    loadProg();
    frameW[0] = 16'hF55F; frameW[1] = 16'h9999; frameW[2] = 16'h1AB2; frameW[3] = 16'h0;
    runFrame("R2", 4, 3, 0);
    check("R2 mask result", 32'(flags), 32'h0007);

    // R4 R13: or, no-op, same-cycle offset
    clearProg();
    progM[0] = mkIns(1, 7, 0, 15, 16'h1111);
    progM[1] = mkIns(3, 7, 1, 15, 16'h2222);
    progM[2] = mkIns(0, 7, 0, 15, 16'h0000);
    progM[3] = mkIns(1, 9, 3, 12, 16'h4400);
    loadProg();
    frameW[0] = 16'h1110; frameW[1] = 16'h2222; frameW[2] = 16'h0; frameW[3] = 16'h44FF;
    runFrame("R13", 4, 3, 1);
    check("R4 or and nop", 32'(flags), 32'h0280);

    // R8: end of frame before progEnd
    runFrame("R8", 2, 20, 0);

    // R9: words after done are dropped
    for (int k = 0; k < 6; k++) frameW[k] = 16'(k * 16'h1111);
    runFrame("R9", 6, 2, 2);
    held = flags;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      wordValid = 1'b1; sof = 1'b0; eof = 1'b0; wordData = 16'h2222;
    end
    idle(); idle();
    check("R9 flags held", 32'(flags), 32'(held));
    check("R9 no extra done", doneCnt, 1);

    // R12: abandoned partial frame
    progEnd = 6'd30;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      wordValid = 1'b1; sof = (k == 0); eof = 1'b0; wordData = 16'h1110;
    end
    runFrame("R12", 4, 30, 0);

    // R5 R6: random programs and frames with idle gaps
    for (int t = 0; t < 40; t++) begin
      logic [15:0] pool [4];
      int len, endA;
      pool[0] = 16'h1234; pool[1] = 16'hABCD; pool[2] = 16'h12CD; pool[3] = 16'($urandom());
      for (int a = 0; a < 64; a++)
        progM[a] = mkIns($urandom_range(3, 0), $urandom_range(15, 0), $urandom_range(a, 0),
                         $urandom_range(15, 0), pool[$urandom_range(3, 0)]);
      for (int k = 0; k < 64; k++) frameW[k] = pool[$urandom_range(3, 0)];
      loadProg();
      len  = $urandom_range(40, 1);
      endA = $urandom_range(40, 0);
      runFrame((t % 2 == 0) ? "R5" : "R6", len, endA, $urandom_range(2, 0));
    end

    // R10: offset beyond address
    clearProg();
    progM[0] = mkIns(1, 4, 0, 0, 16'h0);
    progM[2] = mkIns(1, 4, 5, 15, 16'h5555);
    loadProg();
    for (int k = 0; k < 8; k++) frameW[k] = 16'h5555;
    runFrame("R10", 8, 3, 0);
    check("R10 false compare", 32'(flags), 32'h0000);
    check("R10 error set", 32'(progErr), 1);
    clearProg();
    loadProg();
    runFrame("R10", 3, 2, 0);
    check("R10 error sticky", 32'(progErr), 1);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule